// File: doc/BRIEF.md
# Multichannel SPI ADC Scan Controller

This block is an SPI master that repeatedly samples all eight single-ended inputs of an external 10-bit converter, one input per timer tick. An internal divider produces a trigger every `TRIG_DIV` system clocks. On each trigger the controller pulls the active-low select line down and waits out a setup interval. It then clocks a 32-bit command out as two back-to-back 16-bit words, MSB first. At the same time it shifts in the converter's reply. The low ten bits of the reply are written into the result slot of the channel just converted, and the channel pointer moves on.

A trigger that arrives before the current conversion has finished is treated as an overrun. The transfer is abandoned and the select line is held high for a minimum deselect time. An error counter is bumped, and a fresh attempt starts on the same channel. Software-side logic reads the result slots and the error counter through a simple registered read port. Reading the counter also clears it.

Top module: `adc_scan_ctrl`

## Requirements
- R1: The first 16 bits sent on MOSI in every conversion are 0x0001, so the start bit is the sixteenth bit clocked out.
- R2: The second 16-bit word sent is bit 15 = 1 (single-ended), bits 14:12 = channel number, bits 11:0 = 0.
- R3: The value stored for a conversion is bits 9:0 of the 32 bits received on MISO (first word in bits 31:16), zero-extended to 16 bits; all higher received bits are discarded.
- R4: Channels are converted in the order 0,1,...,7,0,...; the pointer advances only after a conversion completes, and the result goes to the slot of the channel that was converted.
- R5: The select line goes low at least `CS_SETUP` clocks before the first rising SCLK edge, stays low across exactly 32 SCLK pulses, and returns high after the last bit.
- R6: A trigger during a conversion in progress forces the select line high for at least `CS_DESEL` clocks, increments the error counter by one, stores nothing, and retries the same channel.
- R7: SPI mode 0: SCLK idles low while the select line is high, each SCLK high phase lasts `CLK_DIV/2` clocks, and MOSI changes only on a falling SCLK edge or before the first rising edge of a transfer.
- R8: After reset the select line is high, SCLK is low, every result slot reads 0xFFFF and the error counter reads 0.
- R9: A read with `rd_en` high returns, on the next cycle, result slot `rd_addr` for addresses 0 to 7, the error counter for address 8, and 0 for addresses 9 to 15.
- R10: Reading address 8 clears the error counter; if an overrun happens in the same cycle as the clearing read, the counter becomes 1.
- R11: A conversion is started exactly once every `TRIG_DIV` clocks when no overrun occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | output | 1 | Serial clock to the converter |
| spi_mosi | output | 1 | Command data to the converter |
| spi_miso | input | 1 | Reply data from the converter |
| spi_cs_n | output | 1 | Active-low converter select |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 4 | Read address: 0-7 result slots, 8 error counter |
| rd_data | output | 16 | Read data, valid the cycle after `rd_en` |

## Verification
The hardest case to reach from the ports is an error-counter clear that lands in exactly the same cycle as an overrun increment. The bench uses a second instance whose trigger period is shorter than one conversion, so every later trigger is an overrun. It watches that instance's select line rise on an abort, and from there it counts one full trigger period before it issues the clearing read, so the read coincides with the next overrun. The same instance captures the partial command of each aborted attempt to show that the retry keeps channel 0.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;

    localparam int unsigned NUM_CH   = 8;
    localparam int unsigned CH_W     = $clog2(NUM_CH);
    localparam int unsigned RES_W    = 10;
    localparam int unsigned SLOT_W   = 16;
    localparam int unsigned WORD_W   = 16;
    localparam int unsigned CMD_W    = 2 * WORD_W;
    localparam int unsigned ADDR_W   = $clog2(NUM_CH + 1);
    localparam int unsigned ERR_ADDR = NUM_CH;

    localparam logic [WORD_W-1:0] START_WORD = 16'h0001;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SETUP = 2'd1,
        ST_XFER  = 2'd2,
        ST_DESEL = 2'd3
    } scan_state_e;

    // Two-word command: lone start bit word, then mode/channel word.
    function automatic logic [CMD_W-1:0] build_cmd(input logic [CH_W-1:0] ch);
        logic [WORD_W-1:0] sel;
        sel = '0;
        sel[WORD_W-1] = 1'b1;
        sel[WORD_W-2 -: CH_W] = ch;
        return {START_WORD, sel};
    endfunction

endpackage

// File: rtl/adc_scan_trig.sv
module adc_scan_trig #(
    parameter int unsigned TRIG_DIV = 13500
) (
    input  logic clk,
    input  logic rst_n,
    output logic trig
);
    localparam int unsigned CNT_W = (TRIG_DIV > 1) ? $clog2(TRIG_DIV) : 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             pulse;
    } trig_reg_t;

    trig_reg_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        r_d.pulse = 1'b0;
        if (r_q.cnt == CNT_W'(TRIG_DIV - 1)) begin
            r_d.cnt   = '0;
            r_d.pulse = 1'b1;
        end else begin
            r_d.cnt = r_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign trig = r_q.pulse;

endmodule

// File: rtl/adc_scan_shift.sv
module adc_scan_shift #(
    parameter int unsigned CLK_DIV = 16,
    parameter int unsigned TX_W    = 32,
    parameter int unsigned KEEP_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              abort,
    input  logic [TX_W-1:0]   tx_word,
    input  logic              miso,
    output logic              done,
    output logic [KEEP_W-1:0] rx_low,
    output logic              sclk,
    output logic              mosi
);
    localparam int unsigned HALF  = CLK_DIV / 2;
    localparam int unsigned PH_W  = (HALF > 1) ? $clog2(HALF) : 1;
    localparam int unsigned BIT_W = $clog2(TX_W);

    typedef struct packed {
        logic              busy;
        logic              sclk;
        logic              done;
        logic [PH_W-1:0]   ph;
        logic [BIT_W-1:0]  nbit;
        logic [TX_W-1:0]   tx;
        logic [KEEP_W-1:0] rx;
    } shf_reg_t;

    shf_reg_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        s_d.done = 1'b0;
        if (abort) begin
            s_d.busy = 1'b0;
            s_d.sclk = 1'b0;
            s_d.tx   = '0;
            s_d.ph   = '0;
        end else if (start && !s_q.busy) begin
            s_d.busy = 1'b1;
            s_d.sclk = 1'b0;
            s_d.ph   = '0;
            s_d.nbit = '0;
            s_d.tx   = tx_word;
            s_d.rx   = '0;
        end else if (s_q.busy) begin
            if (s_q.ph == PH_W'(HALF - 1)) begin
                s_d.ph = '0;
                if (!s_q.sclk) begin
                    // rising edge: sample the converter
                    s_d.sclk = 1'b1;
                    s_d.rx   = {s_q.rx[KEEP_W-2:0], miso};
                end else begin
                    // falling edge: present next bit or finish
                    s_d.sclk = 1'b0;
                    if (s_q.nbit == BIT_W'(TX_W - 1)) begin
                        s_d.busy = 1'b0;
                        s_d.done = 1'b1;
                        s_d.tx   = '0;
                    end else begin
                        s_d.nbit = s_q.nbit + 1'b1;
                        s_d.tx   = {s_q.tx[TX_W-2:0], 1'b0};
                    end
                end
            end else begin
                s_d.ph = s_q.ph + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign done   = s_q.done;
    assign rx_low = s_q.rx;
    assign sclk   = s_q.sclk;
    assign mosi   = s_q.tx[TX_W-1];

endmodule

// File: rtl/adc_scan_bank.sv
module adc_scan_bank
    import adc_scan_pkg::*;
#(
    parameter int unsigned ERR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CH_W-1:0]   wr_ch,
    input  logic [RES_W-1:0]  wr_val,
    input  logic              err_inc,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [SLOT_W-1:0] rd_data,
    output logic [ERR_W-1:0]  err_cnt
);
    typedef struct packed {
        logic [NUM_CH-1:0][SLOT_W-1:0] slot;
        logic [ERR_W-1:0]              err;
        logic [SLOT_W-1:0]             rd;
    } bank_reg_t;

    bank_reg_t b_d, b_q;
    logic [NUM_CH-1:0] slot_we;
    logic              err_clr;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_we
        assign slot_we[g] = wr_en && (wr_ch == CH_W'(g));
    end

    assign err_clr = rd_en && (rd_addr == ADDR_W'(ERR_ADDR));

    always_comb begin
        b_d = b_q;
        for (int i = 0; i < NUM_CH; i++) begin
            if (slot_we[i]) b_d.slot[i] = SLOT_W'(wr_val);
        end
        if (err_clr)      b_d.err = err_inc ? ERR_W'(1) : '0;
        else if (err_inc) b_d.err = b_q.err + 1'b1;
        if (rd_en) begin
            if (rd_addr < ADDR_W'(NUM_CH))           b_d.rd = b_q.slot[rd_addr[CH_W-1:0]];
            else if (rd_addr == ADDR_W'(ERR_ADDR))   b_d.rd = SLOT_W'(b_q.err);
            else                                     b_d.rd = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            b_q.slot <= '1;
            b_q.err  <= '0;
            b_q.rd   <= '0;
        end else begin
            b_q <= b_d;
        end
    end

    assign rd_data = b_q.rd;
    assign err_cnt = b_q.err;

endmodule

// File: rtl/adc_scan_ctrl.sv
module adc_scan_ctrl
    import adc_scan_pkg::*;
#(
    parameter int unsigned CLK_DIV  = 16,
    parameter int unsigned TRIG_DIV = 13500,
    parameter int unsigned CS_SETUP = 13,
    parameter int unsigned CS_DESEL = 33,
    parameter int unsigned ERR_W    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              spi_sclk,
    output logic              spi_mosi,
    input  logic              spi_miso,
    output logic              spi_cs_n,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [SLOT_W-1:0] rd_data
);
    localparam int unsigned TMR_MAX = (CS_SETUP > CS_DESEL) ? CS_SETUP : CS_DESEL;
    localparam int unsigned TMR_W   = $clog2(TMR_MAX + 1);

    typedef struct packed {
        scan_state_e     state;
        logic [CH_W-1:0] ch;
        logic [TMR_W-1:0] tmr;
        logic            cs_n;
    } ctl_reg_t;

    ctl_reg_t c_d, c_q;

    logic             trig;
    logic             conv_busy;
    logic             overrun;
    logic             shf_start, shf_abort, shf_done;
    logic             res_we;
    logic [RES_W-1:0] rx_low;
    logic [ERR_W-1:0] err_cnt;

    adc_scan_trig #(.TRIG_DIV(TRIG_DIV)) u_trig (
        .clk   (clk),
        .rst_n (rst_n),
        .trig  (trig)
    );

    adc_scan_shift #(.CLK_DIV(CLK_DIV), .TX_W(CMD_W), .KEEP_W(RES_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (shf_start),
        .abort   (shf_abort),
        .tx_word (build_cmd(c_q.ch)),
        .miso    (spi_miso),
        .done    (shf_done),
        .rx_low  (rx_low),
        .sclk    (spi_sclk),
        .mosi    (spi_mosi)
    );

    adc_scan_bank #(.ERR_W(ERR_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (res_we),
        .wr_ch   (c_q.ch),
        .wr_val  (rx_low),
        .err_inc (overrun),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .err_cnt (err_cnt)
    );

    assign conv_busy = (c_q.state != ST_IDLE);
    assign overrun   = trig && conv_busy;

    always_comb begin
        c_d       = c_q;
        shf_start = 1'b0;
        shf_abort = 1'b0;
        res_we    = 1'b0;
        if (overrun) begin
            // stale conversion: drop it, deselect, retry same channel
            shf_abort = 1'b1;
            c_d.state = ST_DESEL;
            c_d.tmr   = '0;
            c_d.cs_n  = 1'b1;
        end else begin
            unique case (c_q.state)
                ST_IDLE: begin
                    if (trig) begin
                        c_d.state = ST_SETUP;
                        c_d.tmr   = '0;
                        c_d.cs_n  = 1'b0;
                    end
                end
                ST_SETUP: begin
                    if (c_q.tmr == TMR_W'(CS_SETUP - 1)) begin
                        shf_start = 1'b1;
                        c_d.state = ST_XFER;
                        c_d.tmr   = '0;
                    end else begin
                        c_d.tmr = c_q.tmr + 1'b1;
                    end
                end
                ST_XFER: begin
                    if (shf_done) begin
                        res_we    = 1'b1;
                        c_d.ch    = c_q.ch + 1'b1;
                        c_d.cs_n  = 1'b1;
                        c_d.state = ST_IDLE;
                    end
                end
                ST_DESEL: begin
                    if (c_q.tmr == TMR_W'(CS_DESEL - 1)) begin
                        c_d.state = ST_SETUP;
                        c_d.tmr   = '0;
                        c_d.cs_n  = 1'b0;
                    end else begin
                        c_d.tmr = c_q.tmr + 1'b1;
                    end
                end
                default: c_d.state = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q.state <= ST_IDLE;
            c_q.ch    <= '0;
            c_q.tmr   <= '0;
            c_q.cs_n  <= 1'b1;
        end else begin
            c_q <= c_d;
        end
    end

    assign spi_cs_n = c_q.cs_n;

endmodule

// File: rtl/adc_scan_chk.sv
module adc_scan_chk
    import adc_scan_pkg::*;
#(
    parameter int unsigned CS_SETUP = 13,
    parameter int unsigned CS_DESEL = 33,
    parameter int unsigned ERR_W    = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n,
    input logic              sclk,
    input logic              mosi,
    input logic              trig,
    input logic              conv_busy,
    input logic              rd_en,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [ERR_W-1:0]  err_cnt
);
    logic [15:0] lo_cnt, hi_cnt;
    logic        abort_seen;
    logic        clr_rd;

    assign clr_rd = rd_en && (rd_addr == ADDR_W'(ERR_ADDR));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_cnt     <= '0;
            hi_cnt     <= '0;
            abort_seen <= 1'b0;
        end else begin
            lo_cnt <= cs_n ? '0 : ((lo_cnt == '1) ? lo_cnt : lo_cnt + 1'b1);
            hi_cnt <= !cs_n ? '0 : ((hi_cnt == '1) ? hi_cnt : hi_cnt + 1'b1);
            if (trig && conv_busy) abort_seen <= 1'b1;
            else if (!cs_n)        abort_seen <= 1'b0;
        end
    end

    AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk) else $error("sclk high while deselected"); // R7

    AST_MOSI_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(mosi)) else $error("mosi moved while sclk high"); // R7

    AST_CS_SETUP_TIME: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk) |-> (lo_cnt >= 16'(CS_SETUP))) else $error("select setup too short"); // R5

    AST_DESEL_TIME: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cs_n) && abort_seen) |-> (hi_cnt >= 16'(CS_DESEL))) else $error("deselect too short"); // R6

    AST_ERR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && conv_busy && !clr_rd) |=> (err_cnt == ERR_W'($past(err_cnt) + 1'b1))) else $error("overrun not counted"); // R6

    AST_CLR_KEEPS_NEW: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && conv_busy && clr_rd) |=> (err_cnt == ERR_W'(1))) else $error("clear lost overrun"); // R10

    AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_rd && !(trig && conv_busy)) |=> (err_cnt == '0)) else $error("clear failed"); // R10

endmodule

bind adc_scan_ctrl adc_scan_chk #(
    .CS_SETUP (CS_SETUP),
    .CS_DESEL (CS_DESEL),
    .ERR_W    (ERR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (spi_cs_n),
    .sclk      (spi_sclk),
    .mosi      (spi_mosi),
    .trig      (trig),
    .conv_busy (conv_busy),
    .rd_en     (rd_en),
    .rd_addr   (rd_addr),
    .err_cnt   (err_cnt)
);

// File: tb/adc_scan_ctrl_test.sv
`timescale 1ns/1ps
module adc_scan_ctrl_test;
    localparam int CLK_DIV  = 4;
    localparam int TRIG_A   = 400;
    localparam int TRIG_B   = 130;
    localparam int CS_SETUP = 13;
    localparam int CS_DESEL = 33;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic        sclk_a, mosi_a, cs_a, miso_a;
    logic        rd_en_a = 1'b0;
    logic [3:0]  rd_addr_a = '0;
    logic [15:0] rd_data_a;
    logic        sclk_b, mosi_b, cs_b;
    logic        rd_en_b = 1'b0;
    logic [3:0]  rd_addr_b = '0;
    logic [15:0] rd_data_b;

    adc_scan_ctrl #(.CLK_DIV(CLK_DIV), .TRIG_DIV(TRIG_A), .CS_SETUP(CS_SETUP),
                    .CS_DESEL(CS_DESEL), .ERR_W(16)) uut (
        .clk(clk), .rst_n(rst_n), .spi_sclk(sclk_a), .spi_mosi(mosi_a),
        .spi_miso(miso_a), .spi_cs_n(cs_a), .rd_en(rd_en_a),
        .rd_addr(rd_addr_a), .rd_data(rd_data_a));

    adc_scan_ctrl #(.CLK_DIV(CLK_DIV), .TRIG_DIV(TRIG_B), .CS_SETUP(CS_SETUP),
                    .CS_DESEL(CS_DESEL), .ERR_W(16)) uut_ovr (
        .clk(clk), .rst_n(rst_n), .spi_sclk(sclk_b), .spi_mosi(mosi_b),
        .spi_miso(1'b0), .spi_cs_n(cs_b), .rd_en(rd_en_b),
        .rd_addr(rd_addr_b), .rd_data(rd_data_b));

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;
    int unsigned cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic check_ge(input string req, input int act, input int lim);
        n_tests++;
        if (act < lim) begin
            n_fail++;
            $display("FAIL %s: got %0d expected >= %0d", req, act, lim);
        end
    endtask

    task automatic rd_a(input logic [3:0] a, output logic [15:0] d);
        @(negedge clk); rd_en_a = 1'b1; rd_addr_a = a;
        @(negedge clk); rd_en_a = 1'b0; d = rd_data_a;
    endtask

    task automatic rd_b(input logic [3:0] a, output logic [15:0] d);
        @(negedge clk); rd_en_b = 1'b1; rd_addr_b = a;
        @(negedge clk); rd_en_b = 1'b0; d = rd_data_b;
    endtask

    function automatic logic [9:0] reply_val(input int n, input int ch);
        if (n == 2) return 10'h000;
        if (n == 3) return 10'h3FF;
        return 10'((n * 173 + ch * 29 + 5) % 1024);
    endfunction

    // ---------------- converter model for uut ----------------
    logic [31:0] reply_a;
    logic [31:0] cmd_a;
    int          nrise_a = 0, bit_a = 0, conv_n = 0, exp_ch = 0;
    bit          sel_a = 1'b0;
    logic [15:0] exp_slot [8];
    int          last_fall = -1;
    int          rise_cyc = 0;
    int          sclk_bad = 0;

    initial for (int i = 0; i < 8; i++) exp_slot[i] = 16'hFFFF;
    initial miso_a = 1'b0;

    always @(negedge cs_a) begin
        sel_a   = 1'b1;
        nrise_a = 0;
        bit_a   = 0;
        cmd_a   = '0;
        reply_a = {((conv_n % 2) == 1) ? 22'h3FFFFF : 22'h15A5A5, reply_val(conv_n, exp_ch)};
        miso_a  = reply_a[31];
        if (last_fall >= 0 && conv_n < 6)
            check("R11 trigger period", 32'(int'(cyc) - last_fall), 32'(TRIG_A));
        last_fall = int'(cyc);
    end

    always @(posedge sclk_a) begin
        cmd_a = {cmd_a[30:0], mosi_a};
        nrise_a++;
        rise_cyc = int'(cyc);
    end

    always @(negedge sclk_a) begin
        bit_a++;
        if (bit_a < 32) miso_a = reply_a[31 - bit_a];
        if (int'(cyc) - rise_cyc != CLK_DIV / 2) sclk_bad++;
    end

    always @(posedge cs_a) begin
        if (sel_a) begin
            sel_a = 1'b0;
            check("R5 sclk pulses per select", 32'(nrise_a), 32);
            check("R1 first word", {16'h0, cmd_a[31:16]}, 32'h0001);
            check("R2/R4 second word channel", {16'h0, cmd_a[15:0]},
                  {16'h0, 1'b1, 3'(exp_ch), 12'h000});
            exp_slot[exp_ch] = {6'h0, reply_val(conv_n, exp_ch)};
            exp_ch = (exp_ch + 1) % 8;
            conv_n++;
        end
    end

    // setup time and MOSI-change monitor, sampled mid-cycle
    int   lo_run = 0;
    int   setup_min = 1000;
    bit   prev_mosi = 1'b0, prev_sclk = 1'b0, prev_cs = 1'b1;
    int   mosi_bad = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (!cs_a && nrise_a == 0) lo_run++;
            if (cs_a) lo_run = 0;
            if (sclk_a && !prev_sclk && nrise_a == 1 && lo_run < setup_min) setup_min = lo_run;
            if (mosi_a != prev_mosi && !(prev_sclk && !sclk_a) && !(!cs_a && nrise_a == 0))
                mosi_bad++;
            if (cs_a && sclk_a) mosi_bad++;
        end
        prev_mosi = mosi_a; prev_sclk = sclk_a; prev_cs = cs_a;
    end

    // ---------------- overrun instance monitors ----------------
    logic [31:0] cmd_b;
    int          nrise_b = 0, abort_n = 0, hi_start = 0, desel_min = 1000;
    bit          sel_b = 1'b0;
    always @(negedge cs_b) begin
        if (sel_b == 1'b0 && abort_n > 0) begin
            if (int'(cyc) - hi_start < desel_min) desel_min = int'(cyc) - hi_start;
        end
        sel_b = 1'b1; nrise_b = 0; cmd_b = '0;
    end
    always @(posedge sclk_b) begin
        cmd_b = {cmd_b[30:0], mosi_b};
        nrise_b++;
    end
    always @(posedge cs_b) begin
        if (sel_b) begin
            sel_b = 1'b0;
            hi_start = int'(cyc);
            abort_n++;
            if (abort_n >= 2 && abort_n <= 5) begin
                check_ge("R6 bits before abort", nrise_b, 20);
                // bit index j from MSB is cmd_b[nrise_b-1-j]; mode bit j=16, channel j=17..19
                check("R6 retry mode bit", 32'(cmd_b[nrise_b - 17]), 32'h1);
                check("R6 retry same channel",
                      {29'h0, cmd_b[nrise_b - 18], cmd_b[nrise_b - 19], cmd_b[nrise_b - 20]}, 32'h0);
            end
        end
    end

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    // ---------------- main sequence ----------------
    initial begin
        logic [15:0] d;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R8 cs_n high after reset", 32'(cs_a), 32'h1);
        check("R8 sclk low after reset", 32'(sclk_a), 32'h0);
        for (int a = 0; a < 16; a++) begin
            rd_a(4'(a), d);
            if (a < 8)       check("R8/R9 slot reset value", {16'h0, d}, 32'hFFFF);
            else if (a == 8) check("R8/R9 error counter reset", {16'h0, d}, 32'h0);
            else             check("R9 unused address", {16'h0, d}, 32'h0);
        end

        wait (conv_n >= 20);
        @(negedge clk);
        for (int a = 0; a < 8; a++) begin
            rd_a(4'(a), d);
            check("R3/R4 stored result", {16'h0, d}, {16'h0, exp_slot[a]});
        end
        rd_a(4'd8, d);
        check("R6 no error without overrun", {16'h0, d}, 32'h0);
        check_ge("R5 select setup clocks", setup_min, CS_SETUP);
        check("R7 mosi changes only on sclk fall", 32'(mosi_bad), 32'h0);
        check("R7 sclk high phase length", 32'(sclk_bad), 32'h0);

        // overrun instance: nothing stored, deselect time
        for (int a = 0; a < 8; a++) begin
            rd_b(4'(a), d);
            check("R6 no store on overrun", {16'h0, d}, 32'hFFFF);
        end
        check_ge("R6 deselect clocks", desel_min, CS_DESEL);

        // clear coinciding with an overrun increment
        @(posedge cs_b);
        repeat (TRIG_B - 1) @(negedge clk);
        rd_b(4'd8, d);
        check_ge("R6 errors counted", int'(d), 1);
        rd_b(4'd8, d);
        check("R10 clear with same-cycle overrun", {16'h0, d}, 32'h1);

        // exact count over ten trigger periods
        rd_b(4'd8, d);
        repeat (10 * TRIG_B - 2) @(negedge clk);
        rd_b(4'd8, d);
        check("R6/R10 errors in ten periods", {16'h0, d}, 32'd10);
        rd_b(4'd8, d);
        check("R10 counter cleared by read", {16'h0, d}, 32'h0);

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule